// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit works out how many vector elements the machine can hold at once and then grants length requests against that limit. A configuration write gives the number of integer and floating-point registers each element uses. A separate write gives a bank-enable mask. From these values and the registers-per-bank constant, the unit computes a maximum vector length. It scales that length by the number of enabled banks and clamps it to the hardware thread ceiling. A set-length request then receives the smaller of its requested length and that maximum.

The maximum length is recomputed after every configuration or mask write. The work is done by a bit-serial restoring divider, one quotient bit per cycle. While the divider runs, `busy` is high and set-length requests are held off. A request is served only in a cycle where the unit reports ready. Its grant appears, with a one-cycle valid pulse, on the following cycle.

Top module: `vlcu_top`

## Requirements
- R1: The bank mask is bits [7:0] of `mask_wdata`, and bits [15:8] have no effect. The enabled bank count is the number of ones in the mask. A configuration-only write keeps the previous mask, and a mask-only write keeps the previous register usage.
- R2: When `int_used + fp_used` is 0 or 1, the maximum length is `regs_per_bank` times the enabled bank count, before the cap.
- R3: When `int_used + fp_used` is 2 or more, the maximum length is floor(`regs_per_bank` / (`int_used + fp_used - 1`)) times the enabled bank count, before the cap.
- R4: `max_len` never exceeds 32, the hardware thread ceiling. Larger products read as 32.
- R5: An accepted request sets `grant_valid` for the next cycle only, with `grant_len` = min(`max_len`, `setvl_len`).
- R6: A write raises `busy` on the next cycle and holds it for exactly 8 cycles (the `regs_per_bank` width). `max_len` takes its new value on the edge where `busy` falls and is otherwise unchanged.
- R7: `setvl_ready` is high only when not busy and no write is present in the same cycle. A request made while not ready produces no grant, and it is served with the new maximum once ready.
- R8: A write arriving while busy restarts the computation with the latest values. `busy` then lasts 8 cycles from that write.
- R9: After reset, `max_len`, `grant_len`, `grant_valid` and `busy` are 0 and `setvl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Bank-mask write strobe |
| mask_wdata | input | 16 | Mask write value, low byte used |
| cfg_we | input | 1 | Register-usage write strobe |
| int_used | input | 6 | Integer registers per element |
| fp_used | input | 6 | Floating-point registers per element |
| regs_per_bank | input | 8 | Registers per bank, sampled at a write |
| setvl_req | input | 1 | Set-length request |
| setvl_len | input | 16 | Requested length |
| setvl_ready | output | 1 | Request can be accepted this cycle |
| busy | output | 1 | Maximum length being recomputed |
| max_len | output | 6 | Current maximum vector length |
| grant_valid | output | 1 | Grant pulse |
| grant_len | output | 6 | Granted length |

## Verification
The usage sums cover 0 and 1 (no division) and small sums with exact and inexact quotients. They also include a quotient of zero and the largest possible sum. Together these separate the two formula branches and expose off-by-one errors in the divisor. The masks range from a single bank to all eight, and some carry set upper bits, which shows whether the population count is taken over the right field. Requests below, equal to and above the maximum, together with products far above 32, separate the minimum selection from the cap. Directed runs hold requests across busy periods, collide a request with a write, restart the divider mid-run and write the mask alone.

// File: rtl/vlcu_pkg.sv
package vlcu_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DIV  = 1'b1
    } phase_e;

endpackage

// File: rtl/vlcu_popcount.sv
module vlcu_popcount #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [OUT_W-1:0] count_o
);

    logic [OUT_W-1:0] acc [IN_W+1];

    assign acc[0] = '0;

    for (genvar g = 0; g < IN_W; g++) begin : g_sum
        assign acc[g+1] = acc[g] + OUT_W'(bits_i[g]);
    end

    assign count_o = acc[IN_W];

endmodule

// File: rtl/vlcu_div_step.sv
module vlcu_div_step #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned REM_W = DIV_W + 1,
    parameter int unsigned QUO_W = 8
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [QUO_W-1:0] quo_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [REM_W-1:0] rem_o,
    output logic [QUO_W-1:0] quo_o
);

    logic [REM_W:0] trial;
    logic [REM_W:0] div_ext;
    logic           fits;

    always_comb begin
        trial   = {rem_i, quo_i[QUO_W-1]};
        div_ext = (REM_W+1)'(div_i);
        fits    = (trial >= div_ext);
        rem_o   = fits ? REM_W'(trial - div_ext) : REM_W'(trial);
        quo_o   = {quo_i[QUO_W-2:0], fits};
    end

endmodule

// File: rtl/vlcu_scale.sv
module vlcu_scale #(
    parameter int unsigned QUO_W       = 8,
    parameter int unsigned POP_W       = 4,
    parameter int unsigned MAX_THREADS = 32,
    parameter int unsigned LEN_W       = $clog2(MAX_THREADS + 1)
) (
    input  logic [QUO_W-1:0] quo_i,
    input  logic [POP_W-1:0] banks_i,
    output logic [LEN_W-1:0] len_o
);

    localparam int unsigned PROD_W = QUO_W + POP_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(quo_i) * PROD_W'(banks_i);
        if (prod > PROD_W'(MAX_THREADS)) begin
            len_o = LEN_W'(MAX_THREADS);
        end else begin
            len_o = LEN_W'(prod);
        end
    end

endmodule

// File: rtl/vlcu_top.sv
module vlcu_top #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned MASK_W      = 8,
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned RPB_W       = 8,
    parameter int unsigned REQ_W       = 16,
    parameter int unsigned MAX_THREADS = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    mask_we,
    input  logic [DATA_W-1:0]                       mask_wdata,
    input  logic                                    cfg_we,
    input  logic [CNT_W-1:0]                        int_used,
    input  logic [CNT_W-1:0]                        fp_used,
    input  logic [RPB_W-1:0]                        regs_per_bank,
    input  logic                                    setvl_req,
    input  logic [REQ_W-1:0]                        setvl_len,
    output logic                                    setvl_ready,
    output logic                                    busy,
    output logic [$clog2(MAX_THREADS + 1)-1:0]      max_len,
    output logic                                    grant_valid,
    output logic [$clog2(MAX_THREADS + 1)-1:0]      grant_len
);

    localparam int unsigned SUM_W  = CNT_W + 1;
    localparam int unsigned REM_W  = SUM_W + 1;
    localparam int unsigned POP_W  = $clog2(MASK_W + 1);
    localparam int unsigned LEN_W  = $clog2(MAX_THREADS + 1);
    localparam int unsigned STEP_W = $clog2(RPB_W + 1);

    typedef struct packed {
        logic [MASK_W-1:0]      mask;
        logic [SUM_W-1:0]       divisor;
        logic [REM_W-1:0]       rem;
        logic [RPB_W-1:0]       quo;
        logic [STEP_W-1:0]      steps;
        vlcu_pkg::phase_e       phase;
        logic [LEN_W-1:0]       max_len;
        logic                   gnt_vld;
        logic [LEN_W-1:0]       gnt_len;
    } state_t;

    state_t s_d, s_q;

    logic               any_wr;
    logic [SUM_W-1:0]   used_sum;
    logic [SUM_W-1:0]   div_new;
    logic [REM_W-1:0]   rem_nx;
    logic [RPB_W-1:0]   quo_nx;
    logic [POP_W-1:0]   bank_cnt;
    logic [LEN_W-1:0]   scaled;
    logic               unused_hi;

    assign unused_hi = ^mask_wdata[DATA_W-1:MASK_W];

    vlcu_div_step #(
        .DIV_W (SUM_W),
        .REM_W (REM_W),
        .QUO_W (RPB_W)
    ) u_step (
        .rem_i (s_q.rem),
        .quo_i (s_q.quo),
        .div_i (s_q.divisor),
        .rem_o (rem_nx),
        .quo_o (quo_nx)
    );

    vlcu_popcount #(
        .IN_W  (MASK_W),
        .OUT_W (POP_W)
    ) u_pop (
        .bits_i  (s_q.mask),
        .count_o (bank_cnt)
    );

    vlcu_scale #(
        .QUO_W       (RPB_W),
        .POP_W       (POP_W),
        .MAX_THREADS (MAX_THREADS),
        .LEN_W       (LEN_W)
    ) u_scale (
        .quo_i   (quo_nx),
        .banks_i (bank_cnt),
        .len_o   (scaled)
    );

    always_comb begin
        any_wr   = mask_we | cfg_we;
        used_sum = SUM_W'(int_used) + SUM_W'(fp_used);
        div_new  = (used_sum < SUM_W'(2)) ? SUM_W'(1) : used_sum - SUM_W'(1);

        s_d         = s_q;
        s_d.gnt_vld = 1'b0;

        if (any_wr) begin
            if (mask_we) begin
                s_d.mask = mask_wdata[MASK_W-1:0];
            end
            if (cfg_we) begin
                s_d.divisor = div_new;
            end
            s_d.rem   = '0;
            s_d.quo   = regs_per_bank;
            s_d.steps = STEP_W'(RPB_W);
            s_d.phase = vlcu_pkg::PH_DIV;
        end else if (s_q.phase == vlcu_pkg::PH_DIV) begin
            s_d.rem   = rem_nx;
            s_d.quo   = quo_nx;
            s_d.steps = s_q.steps - STEP_W'(1);
            if (s_q.steps == STEP_W'(1)) begin
                s_d.phase   = vlcu_pkg::PH_IDLE;
                s_d.max_len = scaled;
            end
        end else if (setvl_req) begin
            s_d.gnt_vld = 1'b1;
            if (setvl_len < REQ_W'(s_q.max_len)) begin
                s_d.gnt_len = LEN_W'(setvl_len);
            end else begin
                s_d.gnt_len = s_q.max_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mask    <= '0;
            s_q.divisor <= SUM_W'(1);
            s_q.rem     <= '0;
            s_q.quo     <= '0;
            s_q.steps   <= '0;
            s_q.phase   <= vlcu_pkg::PH_IDLE;
            s_q.max_len <= '0;
            s_q.gnt_vld <= 1'b0;
            s_q.gnt_len <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.phase == vlcu_pkg::PH_DIV);
    assign setvl_ready = !busy && !any_wr;
    assign max_len     = s_q.max_len;
    assign grant_valid = s_q.gnt_vld;
    assign grant_len   = s_q.gnt_len;

endmodule

// File: rtl/vlcu_chk.sv
module vlcu_chk #(
    parameter int unsigned LEN_W       = 6,
    parameter int unsigned REQ_W       = 16,
    parameter int unsigned MAX_THREADS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_we,
    input logic             cfg_we,
    input logic             setvl_req,
    input logic [REQ_W-1:0] setvl_len,
    input logic             busy,
    input logic [LEN_W-1:0] max_len,
    input logic             grant_valid,
    input logic [LEN_W-1:0] grant_len
);

    assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we || cfg_we) |=> busy);

    assert_max_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(max_len));

    assert_max_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        max_len <= LEN_W'(MAX_THREADS));

    assert_grant_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_len <= max_len && REQ_W'(grant_len) <= $past(setvl_len)));

    assert_no_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_req && busy) |=> !grant_valid);

    assert_ready_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_req && !busy && !(mask_we || cfg_we)) |=> grant_valid);

endmodule

bind vlcu_top vlcu_chk #(
    .LEN_W       ($clog2(MAX_THREADS + 1)),
    .REQ_W       (REQ_W),
    .MAX_THREADS (MAX_THREADS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we     (mask_we),
    .cfg_we      (cfg_we),
    .setvl_req   (setvl_req),
    .setvl_len   (setvl_len),
    .busy        (busy),
    .max_len     (max_len),
    .grant_valid (grant_valid),
    .grant_len   (grant_len)
);

// File: tb/vlcu_top_tb.sv
`timescale 1ns/1ps
module vlcu_top_tb;

    localparam int NV = 10;
    localparam int BUSY_CYC = 8;

    localparam int T_RPB  [NV] = '{32, 32, 32, 32, 20, 100, 7, 255, 5, 4};
    localparam int T_INT  [NV] = '{ 0,  1,  2,  3,  4,  10, 0,  63, 6, 3};
    localparam int T_FP   [NV] = '{ 0,  0,  0,  2,  3,  10, 1,  63, 0, 3};
    localparam int T_MASK [NV] = '{'h00FF, 'h0001, 'h0003, 'h0005, 'hFF11,
                                   'h00C0, 'h0080, 'h00FF, 'h000F, 'h00FF};
    localparam int T_REQ  [NV] = '{100, 5, 100, 7, 10, 10, 0, 65535, 3, 9};
    localparam int T_MAX  [NV] = '{32, 32, 32, 16, 6, 10, 7, 16, 4, 0};
    localparam int T_GNT  [NV] = '{32, 5, 32, 7, 6, 10, 0, 16, 3, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  int_used = '0;
    logic [5:0]  fp_used = '0;
    logic [7:0]  regs_per_bank = '0;
    logic        setvl_req = 1'b0;
    logic [15:0] setvl_len = '0;
    logic        setvl_ready;
    logic        busy;
    logic [5:0]  max_len;
    logic        grant_valid;
    logic [5:0]  grant_len;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    vlcu_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .cfg_we        (cfg_we),
        .int_used      (int_used),
        .fp_used       (fp_used),
        .regs_per_bank (regs_per_bank),
        .setvl_req     (setvl_req),
        .setvl_len     (setvl_len),
        .setvl_ready   (setvl_ready),
        .busy          (busy),
        .max_len       (max_len),
        .grant_valid   (grant_valid),
        .grant_len     (grant_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // drive a write at a negedge; returns at the next negedge with strobes low
    task automatic do_write(input bit wm, input bit wc, input int rpb,
                            input int iu, input int fu, input int msk);
        @(negedge clk);
        mask_we       = wm;
        cfg_we        = wc;
        regs_per_bank = 8'(rpb);
        int_used      = 6'(iu);
        fp_used       = 6'(fu);
        mask_wdata    = 16'(msk);
        @(negedge clk);
        mask_we = 1'b0;
        cfg_we  = 1'b0;
    endtask

    // count negedges with busy high, starting at the current negedge
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(max_len == 0, "R9", int'(max_len), 0);
        chk(busy == 0, "R9", int'(busy), 0);
        chk(grant_valid == 0, "R9", int'(grant_valid), 0);
        chk(grant_len == 0, "R9", int'(grant_len), 0);
        chk(setvl_ready == 1, "R9", int'(setvl_ready), 1);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            do_write(1'b1, 1'b1, T_RPB[i], T_INT[i], T_FP[i], T_MASK[i]);
            count_busy(nb);
            chk(nb == BUSY_CYC, "R6", nb, BUSY_CYC);
            chk(int'(max_len) == T_MAX[i], "R1/R2/R3/R4", int'(max_len), T_MAX[i]);
            setvl_req = 1'b1;
            setvl_len = 16'(T_REQ[i]);
            @(negedge clk);
            setvl_req = 1'b0;
            chk(grant_valid == 1, "R5", int'(grant_valid), 1);
            chk(int'(grant_len) == T_GNT[i], "R5", int'(grant_len), T_GNT[i]);
            @(negedge clk);
            chk(grant_valid == 0, "R5", int'(grant_valid), 0);
        end

        // R8: restart mid-computation
        do_write(1'b1, 1'b1, 32, 0, 0, 'h00FF);
        repeat (2) @(negedge clk);
        do_write(1'b1, 1'b1, 12, 2, 2, 'h0007);
        count_busy(nb);
        chk(nb == BUSY_CYC, "R8", nb, BUSY_CYC);
        chk(max_len == 12, "R8", int'(max_len), 12);

        // R1: mask-only write keeps usage (divisor 3), upper bits ignored
        do_write(1'b1, 1'b0, 12, 40, 40, 'hAB03);
        count_busy(nb);
        chk(max_len == 8, "R1", int'(max_len), 8);
        // R1: usage-only write keeps the mask (2 banks), usage sum 1
        do_write(1'b0, 1'b1, 12, 1, 0, 'hFFFF);
        count_busy(nb);
        chk(max_len == 24, "R1", int'(max_len), 24);

        // R7: request held across busy is stalled, then served with new max
        do_write(1'b1, 1'b1, 9, 1, 1, 'h0001);
        setvl_req = 1'b1;
        setvl_len = 16'd20;
        nb = 0;
        while (busy && nb < 50) begin
            chk(grant_valid == 0, "R7", int'(grant_valid), 0);
            chk(setvl_ready == 0, "R7", int'(setvl_ready), 0);
            nb++;
            @(negedge clk);
        end
        chk(grant_valid == 0, "R7", int'(grant_valid), 0);
        @(negedge clk);
        setvl_req = 1'b0;
        chk(grant_valid == 1, "R7", int'(grant_valid), 1);
        chk(grant_len == 9, "R7", int'(grant_len), 9);

        // R7: request colliding with a write is not accepted
        @(negedge clk);
        setvl_req = 1'b1;
        setvl_len = 16'd3;
        cfg_we    = 1'b1;
        int_used  = 6'd0;
        fp_used   = 6'd0;
        #1;
        chk(setvl_ready == 0, "R7", int'(setvl_ready), 0);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(grant_valid == 0, "R7", int'(grant_valid), 0);
        chk(busy == 1, "R6", int'(busy), 1);
        count_busy(nb);
        @(negedge clk);
        setvl_req = 1'b0;
        chk(grant_valid == 1, "R7", int'(grant_valid), 1);
        chk(grant_len == 3, "R7", int'(grant_len), 3);
        chk(max_len == 9, "R2", int'(max_len), 9);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule